// File: doc/BRIEF.md
# Global Exception Flag Aggregator

This block gathers the global fault events of a dual-engine coprocessor into a single exception interrupt for the host. Five fault sources arrive as single-cycle pulses: an illegal instruction seen by engine 1, an illegal instruction seen by engine 2, a mismatch reported by the code-memory signature checker, and an exception raised on purpose by the software of either engine. Each pulse sets its own sticky status bit. The interrupt is asserted while any of these bits is set.

The interrupt cannot be masked inside the block. Software that wants silence must disable the fault sources upstream. The host acknowledges the exception with one write that carries a 1 in the clear bit. That write wipes all five status bits together. A source that pulses in the same cycle as the clear write is not lost: its bit stays set, and the interrupt stays up.

Top module: `gexc_aggregator`

## Requirements
- R1: After the asynchronous reset (rst_n low), all five status bits are 0 and `exc_irq` is low.
- R2: A pulse on a source input sets its status bit on the next rising clock edge. The bit positions in `exc_flags` are: bit 0 = engine 1 illegal instruction, bit 1 = engine 2 illegal instruction, bit 2 = signature mismatch, bit 3 = engine 1 software request, bit 4 = engine 2 software request.
- R3: Once a status bit is set, it stays set until a clear write is made, even after its source returns low.
- R4: `exc_irq` is high exactly when at least one status bit is set. It rises one cycle after any source pulse, and no mask can hold it back.
- R5: A host write (`host_wr` high) with `host_clr` high resets all five status bits on the next edge, provided that no source pulses in that cycle.
- R6: When a source pulses in the same cycle as a clear write, that source's bit is 1 after the edge and `exc_irq` stays high. All other bits are cleared.
- R7: A host write with `host_clr` at 0 changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ill_e1 | input | 1 | Illegal-instruction pulse from engine 1 |
| ill_e2 | input | 1 | Illegal-instruction pulse from engine 2 |
| sig_mismatch | input | 1 | Pulse from the code-memory signature checker |
| sw_req_e1 | input | 1 | Software-raised exception pulse from engine 1 |
| sw_req_e2 | input | 1 | Software-raised exception pulse from engine 2 |
| host_wr | input | 1 | Host write strobe to the control register |
| host_clr | input | 1 | Clear bit of the host write data |
| exc_flags | output | 5 | Sticky status bits (read-only) |
| exc_irq | output | 1 | Global exception interrupt to the host |

## Verification
The embedded assertions check on every cycle that each pulse is captured, that set bits hold while no clear arrives, that a clear leaves exactly the coinciding sources, and that no bit or interrupt rises without a source. The bench's scenarios are what show the reset state, the exact bit mapping of each named source, and the visible effect of a write with the clear bit at zero. The bench also shows that the interrupt survives a clear that meets a new fault in the same cycle.

// File: rtl/gexc_aggregator.sv
module gexc_aggregator #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ill_e1,
  input  logic            ill_e2,
  input  logic            sig_mismatch,
  input  logic            sw_req_e1,
  input  logic            sw_req_e2,
  input  logic            host_wr,
  input  logic            host_clr,
  output logic [NSRC-1:0] exc_flags,
  output logic            exc_irq
);

  logic [NSRC-1:0] src_vec;
  logic            clear_cmd;

  assign src_vec   = NSRC'({sw_req_e2, sw_req_e1, sig_mismatch, ill_e2, ill_e1});
  assign clear_cmd = host_wr & host_clr;

  // a source in the clear cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         exc_flags <= '0;
    else if (clear_cmd) exc_flags <= src_vec;
    else                exc_flags <= exc_flags | src_vec;
  end

  assign exc_irq = |exc_flags;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((exc_flags & $past(src_vec)) == $past(src_vec)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_cmd |=> ((exc_flags & $past(exc_flags)) == $past(exc_flags)));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_irq) |-> ($past(src_vec) != '0));

  assert_clear_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd |=> (exc_flags == $past(src_vec)));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((exc_flags & ~$past(exc_flags) & ~$past(src_vec)) == '0));

endmodule

// File: tb/tb_gexc_aggregator.sv
module tb_gexc_aggregator;
  logic clk = 0, rst_n = 0;
  logic ill_e1 = 0, ill_e2 = 0, sig_mismatch = 0, sw_req_e1 = 0, sw_req_e2 = 0;
  logic host_wr = 0, host_clr = 0;
  logic [4:0] exc_flags;
  logic exc_irq;
  int checks = 0, failures = 0;
  logic [4:0] model = '0;

  always #5 clk = ~clk;

  gexc_aggregator dut (.*);

  function automatic logic [4:0] next_model(logic [4:0] cur, logic [4:0] s, logic wr, logic c);
    return (wr && c) ? s : (cur | s);
  endfunction

  task automatic check(string req, logic [4:0] exp_f);
    checks++;
    if (exc_flags !== exp_f || exc_irq !== (|exp_f)) begin
      failures++;
      $display("FAIL %s flags=%b irq=%b expected flags=%b irq=%b", req, exc_flags, exc_irq, exp_f, |exp_f);
    end
  endtask

  task automatic step(logic [4:0] s, logic wr, logic c, string req);
    @(negedge clk);
    {sw_req_e2, sw_req_e1, sig_mismatch, ill_e2, ill_e1} = s;
    host_wr = wr; host_clr = c;
    model = next_model(model, s, wr, c);
    @(negedge clk);
    {sw_req_e2, sw_req_e1, sig_mismatch, ill_e2, ill_e1} = '0;
    host_wr = 0; host_clr = 0;
    check(req, model);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1", 5'b0);
    #22 rst_n = 1;
    @(negedge clk);
    check("R1", 5'b0);
    for (int i = 0; i < 5; i++) begin
      step(5'b1 << i, 0, 0, "R2");
      step('0, 0, 0, "R3");
      step('0, 1, 1, "R5");
    end
    step(5'b00100, 0, 0, "R4");
    step(5'b10000, 0, 0, "R3");
    step('0, 1, 0, "R7");
    step('0, 1, 0, "R7");
    step('0, 1, 1, "R5");
    step(5'b00001, 0, 0, "R4");
    step(5'b01000, 1, 1, "R6");
    step(5'b11111, 1, 1, "R6");
    step('0, 1, 1, "R5");
    step(5'b00010, 1, 1, "R6");
    step('0, 0, 1, "R7");
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] s;
      for (int b = 0; b < 5; b++) s[b] = ($urandom % 8) == 0;
      step(s, ($urandom % 6) == 0, $urandom % 2, "R2/R3/R5/R6/R7 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule